// File: doc/BRIEF.md
# Sprite Attribute Bulk Copy Engine

This block moves one 256-byte page of host memory into the sprite attribute store of a video processor. The host starts a copy by writing a page number to a fixed trigger address. The engine then asks the host processor to halt. Once the halt is acknowledged, it takes over the host bus. It runs alternating read and write cycles: each read fetches one byte from the source page, and the write that follows stores that byte to the single fixed sprite-data register address.

The source address is the page number times 256 plus a running index. The destination address never changes. Each write is also presented on a plain write port for the internal sprite store, with the index and the data. A host write to the trigger address while a copy is running has no effect. If the halt acknowledge arrives while the system marks the cycle as odd, one idle cycle is inserted before the first read, so that reads fall on a fixed phase.

Top module: `spr_dma_engine`

## Requirements
- R1: While reset is active and in the first cycle after it, busy, halt_req, done, dma_rd, dma_wr and spr_we are all low.
- R2: A host write with host_addr equal to TRIG_ADDR (default 16'h4014) raises busy and halt_req in the next cycle. A host write to any other address leaves busy low.
- R3: After a trigger, dma_rd and dma_wr stay low in every cycle until halt_ack has been seen high at a clock edge.
- R4: If odd_cycle is high at the edge where halt_ack is first seen, exactly one cycle with no bus activity follows before the first read. Otherwise the first read occurs in the next cycle.
- R5: Read i (i = 0..255) drives dma_rd high with dma_addr = page*256 + i, in ascending order. Each read is followed directly by one write, and dma_rd and dma_wr are never high together.
- R6: Every write drives dma_wr high with dma_addr = SPR_ADDR (default 16'h2004) and dma_wdata equal to the byte returned by the preceding read. In the same cycle it drives spr_we high with spr_idx = i and spr_data equal to that byte.
- R7: A transfer contains exactly 256 reads and 256 writes. No bus cycle follows the last write.
- R8: busy and halt_req stay high from the cycle after the trigger through the last write. done is high for exactly one cycle, the cycle after the last write, and busy is low in that cycle.
- R9: A host write to TRIG_ADDR while busy is high neither restarts the transfer nor changes its source page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 16 | Host write address |
| host_wdata | input | 8 | Host write data (page number on trigger) |
| halt_ack | input | 1 | Host processor confirms it is halted |
| odd_cycle | input | 1 | System cycle parity, high on odd cycles |
| halt_req | output | 1 | Request to halt the host processor |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last write |
| dma_addr | output | 16 | Bus address driven by the engine |
| dma_rd | output | 1 | Bus read strobe |
| dma_rdata | input | 8 | Bus read data, sampled at the end of a read cycle |
| dma_wr | output | 1 | Bus write strobe |
| dma_wdata | output | 8 | Bus write data |
| spr_we | output | 1 | Sprite store write enable |
| spr_idx | output | 8 | Sprite store write index |
| spr_data | output | 8 | Sprite store write data |

## Verification
The bench builds the engine with its default parameters: 16-bit addresses, byte data and a 256-iteration count. This makes the full copy length and the extreme pages 8'h00 and 8'hFF reachable, including the wrap of the 8-bit index on the last write. Scenarios vary the acknowledge delay and the odd/even parity at acknowledge, which reaches both first-read timings. A re-trigger partway through a copy shows that the page register and the index are left alone.

// File: rtl/spr_dma_pkg.sv
// Package: shared state encoding for the sprite attribute copy engine.
// Assumes: nothing beyond the importing modules.
package spr_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HALT  = 3'd1,
        ST_ALIGN = 3'd2,
        ST_READ  = 3'd3,
        ST_WRITE = 3'd4
    } dma_state_e;

endpackage

// File: rtl/spr_dma_trigger.sv
// Module: decodes host writes to the trigger address and captures the
// source page number.
// Assumes: host writes are single-cycle strobes; a trigger that arrives
// while busy is high is dropped.
module spr_dma_trigger #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PAGE_W    = 8,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              busy,
    output logic              start,
    output logic [PAGE_W-1:0] page_q
);

    logic [PAGE_W-1:0] page_in;

    // Fit the host data to the page width: truncate or zero-extend.
    generate
        if (DATA_W >= PAGE_W) begin : g_trunc
            assign page_in = host_wdata[PAGE_W-1:0];
        end else begin : g_extend
            assign page_in = {{(PAGE_W-DATA_W){1'b0}}, host_wdata};
        end
    endgenerate

    // Start on a trigger write only when no transfer is running.
    always_comb begin
        start = host_wr_en && (host_addr == TRIG_ADDR) && !busy;
    end

    // Hold the page number for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (start) begin
            page_q <= page_in;
        end
    end

endmodule

// File: rtl/spr_dma_seq.sv
// Module: sequencer for halt handshake, phase alignment and alternating
// read/write cycles; keeps the iteration index.
// Assumes: halt_ack stays high once given until busy falls.
module spr_dma_seq
    import spr_dma_pkg::*;
#(
    parameter int unsigned COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               halt_ack,
    input  logic               odd_cycle,
    output dma_state_e         state_q,
    output logic [COUNT_W-1:0] idx_q,
    output logic               done_q
);

    dma_state_e state_d;
    logic       last_iter;

    // The final iteration is the one with the index at all ones.
    always_comb begin
        last_iter = &idx_q;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_HALT;
            ST_HALT:  if (halt_ack) state_d = odd_cycle ? ST_ALIGN : ST_READ;
            ST_ALIGN: state_d = ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = last_iter ? ST_IDLE : ST_READ;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Iteration index: cleared at start, advanced after each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (start) begin
            idx_q <= '0;
        end else if (state_q == ST_WRITE) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // One-cycle completion pulse after the final write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_WRITE) && last_iter;
        end
    end

endmodule

// File: rtl/spr_dma_datapath.sv
// Module: address generation, byte holding register and bus / sprite-port
// drive for the copy engine.
// Assumes: dma_rdata is valid at the end of a read cycle.
module spr_dma_datapath
    import spr_dma_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned COUNT_W = 8,
    parameter int unsigned PAGE_W  = 8,
    parameter logic [ADDR_W-1:0] SPR_ADDR = 16'h2004
) (
    input  logic               clk,
    input  logic               rst_n,
    input  dma_state_e         state_q,
    input  logic [PAGE_W-1:0]  page_q,
    input  logic [COUNT_W-1:0] idx_q,
    input  logic [DATA_W-1:0]  dma_rdata,
    output logic [ADDR_W-1:0]  dma_addr,
    output logic               dma_rd,
    output logic               dma_wr,
    output logic [DATA_W-1:0]  dma_wdata,
    output logic               spr_we,
    output logic [COUNT_W-1:0] spr_idx,
    output logic [DATA_W-1:0]  spr_data
);

    logic [DATA_W-1:0] byte_q;

    // Capture the fetched byte at the end of each read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (state_q == ST_READ) begin
            byte_q <= dma_rdata;
        end
    end

    // Drive the bus: page-relative source on reads, fixed register on writes.
    always_comb begin
        dma_rd    = (state_q == ST_READ);
        dma_wr    = (state_q == ST_WRITE);
        dma_addr  = '0;
        dma_wdata = '0;
        if (dma_rd) begin
            dma_addr = {page_q, idx_q};
        end else if (dma_wr) begin
            dma_addr  = SPR_ADDR;
            dma_wdata = byte_q;
        end
    end

    // Mirror each register write onto the sprite store port.
    always_comb begin
        spr_we   = (state_q == ST_WRITE);
        spr_idx  = idx_q;
        spr_data = byte_q;
    end

endmodule

// File: rtl/spr_dma_engine.sv
// Module: top of the sprite attribute bulk copy engine. A host write to the
// trigger address starts a halt handshake, then one page is copied byte by
// byte to a fixed sprite-data register.
// Assumes: the bus fabric hands the bus to this block while halt_ack is high.
module spr_dma_engine
    import spr_dma_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned COUNT_W = 8,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
    parameter logic [ADDR_W-1:0] SPR_ADDR  = 16'h2004
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               halt_ack,
    input  logic               odd_cycle,
    output logic               halt_req,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  dma_addr,
    output logic               dma_rd,
    input  logic [DATA_W-1:0]  dma_rdata,
    output logic               dma_wr,
    output logic [DATA_W-1:0]  dma_wdata,
    output logic               spr_we,
    output logic [COUNT_W-1:0] spr_idx,
    output logic [DATA_W-1:0]  spr_data
);

    localparam int unsigned PAGE_W = ADDR_W - COUNT_W;

    logic               start;
    logic [PAGE_W-1:0]  page_q;
    dma_state_e         state_q;
    logic [COUNT_W-1:0] idx_q;

    spr_dma_trigger #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PAGE_W   (PAGE_W),
        .TRIG_ADDR(TRIG_ADDR)
    ) u_trigger (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr_en(host_wr_en),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .busy      (busy),
        .start     (start),
        .page_q    (page_q)
    );

    spr_dma_seq #(
        .COUNT_W(COUNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .halt_ack (halt_ack),
        .odd_cycle(odd_cycle),
        .state_q  (state_q),
        .idx_q    (idx_q),
        .done_q   (done)
    );

    spr_dma_datapath #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .COUNT_W (COUNT_W),
        .PAGE_W  (PAGE_W),
        .SPR_ADDR(SPR_ADDR)
    ) u_datapath (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .page_q   (page_q),
        .idx_q    (idx_q),
        .dma_rdata(dma_rdata),
        .dma_addr (dma_addr),
        .dma_rd   (dma_rd),
        .dma_wr   (dma_wr),
        .dma_wdata(dma_wdata),
        .spr_we   (spr_we),
        .spr_idx  (spr_idx),
        .spr_data (spr_data)
    );

    // Busy and the halt request cover every non-idle state.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        halt_req = busy;
    end

endmodule

// File: rtl/spr_dma_checker.sv
// Module: protocol checker for spr_dma_engine, attached through bind.
// Assumes: halt_ack is held high by the host side until busy falls.
module spr_dma_checker #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned COUNT_W = 8,
    parameter logic [ADDR_W-1:0] SPR_ADDR = 16'h2004
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt_ack,
    input logic              halt_req,
    input logic              busy,
    input logic              done,
    input logic              dma_rd,
    input logic              dma_wr,
    input logic [ADDR_W-1:0] dma_addr,
    input logic [DATA_W-1:0] dma_rdata,
    input logic [DATA_W-1:0] dma_wdata
);

    localparam int unsigned XFER_LEN = 1 << COUNT_W;

    logic [COUNT_W:0]  wr_cnt;
    logic [ADDR_W-1:0] last_rd_addr;
    logic              have_rd;

    // Count writes in the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || done) begin
            wr_cnt <= '0;
        end else if (dma_wr) begin
            wr_cnt <= wr_cnt + 1'b1;
        end
    end

    // Remember the previous read address inside a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            have_rd      <= 1'b0;
            last_rd_addr <= '0;
        end else if (dma_rd) begin
            have_rd      <= 1'b1;
            last_rd_addr <= dma_addr;
        end
    end

    AST_NO_BUS_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd || dma_wr) |-> halt_ack); // R3
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_rd && dma_wr)); // R5
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rd |=> dma_wr); // R5
    AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd && have_rd) |-> (dma_addr == last_rd_addr + 1'b1)); // R5
    AST_RD_FIRST_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd && !have_rd) |-> (dma_addr[COUNT_W-1:0] == '0)); // R5
    AST_WR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr |-> (dma_addr == SPR_ADDR)); // R6
    AST_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr |-> (dma_wdata == $past(dma_rdata))); // R6
    AST_WR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_cnt == (COUNT_W+1)'(XFER_LEN))); // R7
    AST_BUS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd || dma_wr) |-> (busy && halt_req)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

endmodule

bind spr_dma_engine spr_dma_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .COUNT_W (COUNT_W),
    .SPR_ADDR(SPR_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_ack (halt_ack),
    .halt_req (halt_req),
    .busy     (busy),
    .done     (done),
    .dma_rd   (dma_rd),
    .dma_wr   (dma_wr),
    .dma_addr (dma_addr),
    .dma_rdata(dma_rdata),
    .dma_wdata(dma_wdata)
);

// File: tb/spr_dma_engine_bench.sv
// Directed bench for spr_dma_engine: one task per scenario, each checking
// its own results at the falling edge.
module spr_dma_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        halt_ack = 1'b0;
    logic        odd_cycle = 1'b0;
    logic        halt_req, busy, done, dma_rd, dma_wr, spr_we;
    logic [15:0] dma_addr;
    logic [7:0]  dma_rdata, dma_wdata, spr_idx, spr_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // Source memory model: byte value computed from its address.
    function automatic logic [7:0] pat(input logic [15:0] a);
        return (a[7:0] + 8'h3B) ^ a[15:8];
    endfunction

    assign dma_rdata = dma_rd ? pat(dma_addr) : 8'h00;

    spr_dma_engine u_spr_dma_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr_en(host_wr_en),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .halt_ack  (halt_ack),
        .odd_cycle (odd_cycle),
        .halt_req  (halt_req),
        .busy      (busy),
        .done      (done),
        .dma_addr  (dma_addr),
        .dma_rd    (dma_rd),
        .dma_rdata (dma_rdata),
        .dma_wr    (dma_wr),
        .dma_wdata (dma_wdata),
        .spr_we    (spr_we),
        .spr_idx   (spr_idx),
        .spr_data  (spr_data)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({busy, halt_req, done, dma_rd, dma_wr, spr_we} == 6'b0, "R1 in reset",
            {busy, halt_req, done, dma_rd, dma_wr, spr_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, halt_req, done, dma_rd, dma_wr, spr_we} == 6'b0, "R1 after reset",
            {busy, halt_req, done, dma_rd, dma_wr, spr_we}, 0);
    endtask

    task automatic t_other_addr(input logic [15:0] a);
        host_wr_en = 1'b1; host_addr = a; host_wdata = 8'h33;
        @(negedge clk);
        host_wr_en = 1'b0;
        chk(!busy && !halt_req, "R2 non-trigger address", busy, 0);
        @(negedge clk);
        chk(!busy && !dma_rd, "R2 still idle", busy, 0);
    endtask

    task automatic t_xfer(input logic [7:0] page, input int ack_delay,
                          input bit odd, input bit retrig);
        host_wr_en = 1'b1; host_addr = 16'h4014; host_wdata = page;
        @(negedge clk);
        host_wr_en = 1'b0;
        chk(busy && halt_req, "R2 trigger starts", {busy, halt_req}, 2'b11);
        for (int d = 0; d < ack_delay; d++) begin
            chk(!dma_rd && !dma_wr, "R3 no bus before ack", {dma_rd, dma_wr}, 0);
            @(negedge clk);
        end
        chk(!dma_rd && !dma_wr, "R3 no bus at ack", {dma_rd, dma_wr}, 0);
        halt_ack = 1'b1; odd_cycle = odd;
        @(negedge clk);
        odd_cycle = 1'b0;
        if (odd) begin
            chk(!dma_rd && !dma_wr && busy, "R4 alignment gap", {dma_rd, dma_wr, busy}, 3'b001);
            @(negedge clk);
        end
        chk(dma_rd, "R4 first read timing", dma_rd, 1);
        for (int i = 0; i < 256; i++) begin
            logic [15:0] ra;
            ra = {page, 8'(i)};
            chk(dma_rd && !dma_wr && dma_addr == ra, "R5 read address",
                dma_addr, ra);
            chk(busy && halt_req, "R8 busy during read", {busy, halt_req}, 2'b11);
            if (retrig && i == 10) begin
                host_wr_en = 1'b1; host_addr = 16'h4014; host_wdata = ~page;
            end
            @(negedge clk);
            host_wr_en = 1'b0;
            chk(dma_wr && !dma_rd && dma_addr == 16'h2004, "R6 write target",
                dma_addr, 16'h2004);
            chk(dma_wdata == pat(ra), "R6 write data", dma_wdata, pat(ra));
            chk(spr_we && spr_idx == 8'(i) && spr_data == pat(ra), "R6 sprite port",
                {spr_we, spr_idx, spr_data}, {1'b1, 8'(i), pat(ra)});
            chk(!done, "R8 no early done", done, 0);
            @(negedge clk);
        end
        chk(done && !busy && !halt_req, "R8 done pulse, busy low",
            {done, busy, halt_req}, 3'b100);
        chk(!dma_rd && !dma_wr, "R7 no cycle after last write", {dma_rd, dma_wr}, 0);
        if (retrig) chk(!dma_rd, "R9 re-trigger ignored", dma_rd, 0);
        halt_ack = 1'b0;
        @(negedge clk);
        chk(!done && !busy && !dma_rd, "R8 done single cycle", {done, busy, dma_rd}, 0);
    endtask

    initial begin
        t_reset();
        t_other_addr(16'h4015);
        t_other_addr(16'h2004);
        t_xfer(8'h02, 0, 1'b0, 1'b0);
        t_xfer(8'h07, 3, 1'b1, 1'b0);
        t_xfer(8'hFF, 1, 1'b0, 1'b1);
        t_xfer(8'h00, 2, 1'b1, 1'b1);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule